// File: doc/BRIEF.md
# I2C Slave Address Front End

This block sits behind the SCL and SDA pins of a bus slave and handles everything up to and including the address acknowledge. It runs on a system clock that is much faster than SCL. Both lines pass through a synchronizer, and the block compares each sample with the one before it to find clock edges and the two bus conditions. SCL is only ever observed. The block has no way to drive SCL.

After a START, the block shifts in one address byte, most significant bit first. The byte matches when its upper four bits equal the fixed device-type prefix and the next three bits equal the strap pins. On a match, the block pulls SDA low for the acknowledge clock. When that clock ends it reports the new transaction, with its direction, to a downstream data engine. On a mismatch it releases the bus and waits for the next START.

The report is a plain control handshake, not a stream. `txn_start` is a single-cycle strobe and has no ready input. A data engine that needs more time to react must use the level of `txn_busy`, which stays high until the next bus condition.

Top module: `i2c_addr_front`

## Requirements
- R1: After reset, `sda_pull`, `txn_start` and `txn_busy` are all low.
- R2: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. Such a change is never taken as a data bit, and a data bit is sampled on the rising edge of SCL.
- R3: Until the first START after reset, bus activity causes no acknowledge and no transaction report.
- R4: A byte is accepted only if its bits 7..4 equal binary 1010.
- R5: Bits 3, 2 and 1 of the address byte must equal `strap[2]`, `strap[1]` and `strap[0]` respectively.
- R6: Bit 0 of the address byte sets the direction: 1 means read (`txn_rw`=1) and 0 means write (`txn_rw`=0).
- R7: On a match, `sda_pull` is high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth clock. It is low at all other times.
- R8: When the acknowledge clock ends, `txn_start` is high for exactly one cycle and `txn_rw` holds the direction. `txn_busy` rises at the same time and stays high, with `txn_rw` held steady, until the next START or STOP.
- R9: On a mismatch, SDA is not pulled, nothing is reported, and later clocks are ignored until the next START.
- R10: A STOP at any point returns the block to idle. A repeated START at any point restarts address reception. Either one releases `sda_pull` and clears `txn_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin, including this block's own pull |
| strap | input | 3 | Pin-strapped select bits, compared with address bits 3..1 |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on SDA |
| txn_start | output | 1 | One-cycle strobe when an addressed transaction begins |
| txn_rw | output | 1 | Direction of the current transaction, 1 = read |
| txn_busy | output | 1 | High from the acknowledge until the next START or STOP |

## Verification
The assertions assume that SCL and SDA are not both changing within one synchronizer window. They also assume that each SCL phase lasts several system clocks, so that the acknowledge pull takes effect and is released while SCL is still low. The stimulus meets these assumptions by driving SCL with six-clock phases and moving SDA only in the middle of an SCL low phase, except when it deliberately forms a START or STOP. The bus model combines the driven SDA with the block's pull through a wired AND, so the block sees its own acknowledge on the line, as it would on a real bus.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int ADDR_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_ACTIVE
  } fe_state_t;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det
  import i2c_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  always_comb begin
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_addr_shift.sv
module i2c_addr_shift
  import i2c_addr_pkg::*;
#(
  parameter int            PREFIX_W = 4,
  parameter logic [PREFIX_W-1:0] PREFIX = 4'b1010,
  parameter int            SEL_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 shift_en,
  input  logic                 bit_in,
  input  logic [SEL_W-1:0]     strap,
  output logic [ADDR_BITS-1:0] addr_q,
  output logic                 full,
  output logic                 match
);
  localparam int CW = $clog2(ADDR_BITS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      cnt    <= '0;
    end else if (clear) begin
      addr_q <= '0;
      cnt    <= '0;
    end else if (shift_en) begin
      addr_q <= {addr_q[ADDR_BITS-2:0], bit_in};
      cnt    <= cnt + 1'b1;
    end

  assign full  = (cnt == CW'(ADDR_BITS));
  assign match = (addr_q[ADDR_BITS-1 -: PREFIX_W] == PREFIX) &&
                 (addr_q[SEL_W:1] == strap);
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_ev_t ev,
  input  logic    full,
  input  logic    match,
  input  logic    rw_bit,
  output logic    shift_clr,
  output logic    shift_en,
  output logic    sda_pull,
  output logic    txn_start,
  output logic    txn_rw,
  output logic    txn_busy
);
  fe_state_t state;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_IDLE;
      sda_pull  <= 1'b0;
      txn_start <= 1'b0;
      txn_rw    <= 1'b0;
      txn_busy  <= 1'b0;
    end else begin
      txn_start <= 1'b0;
      if (ev.start) begin
        state    <= ST_ADDR;
        sda_pull <= 1'b0;
        txn_busy <= 1'b0;
      end else if (ev.stop) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        txn_busy <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (full && ev.scl_fall) begin
              if (match) begin
                state    <= ST_ACK;
                sda_pull <= 1'b1;
              end else begin
                state    <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (ev.scl_fall) begin
              state     <= ST_ACTIVE;
              sda_pull  <= 1'b0;
              txn_start <= 1'b1;
              txn_rw    <= rw_bit;
              txn_busy  <= 1'b1;
            end
          end
          default: state <= state;
        endcase
      end
    end

  assign shift_clr = ev.start;
  assign shift_en  = (state == ST_ADDR) && ev.scl_rise && !full;
endmodule

// File: rtl/i2c_addr_front.sv
module i2c_addr_front
  import i2c_addr_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter int                  PREFIX_W    = 4,
  parameter logic [PREFIX_W-1:0] PREFIX      = 4'b1010,
  parameter int                  SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [SEL_W-1:0] strap,
  output logic             sda_pull,
  output logic             txn_start,
  output logic             txn_rw,
  output logic             txn_busy
);
  logic                 scl_s, sda_s;
  bus_ev_t              ev;
  logic [ADDR_BITS-1:0] addr_q;
  logic                 full, match, shift_clr, shift_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({scl_in, sda_in}),
    .q   ({scl_s, sda_s})
  );

  i2c_cond_det u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .ev    (ev)
  );

  i2c_addr_shift #(.PREFIX_W(PREFIX_W), .PREFIX(PREFIX), .SEL_W(SEL_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (shift_clr),
    .shift_en (shift_en),
    .bit_in   (sda_s),
    .strap    (strap),
    .addr_q   (addr_q),
    .full     (full),
    .match    (match)
  );

  i2c_addr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .full      (full),
    .match     (match),
    .rw_bit    (addr_q[0]),
    .shift_clr (shift_clr),
    .shift_en  (shift_en),
    .sda_pull  (sda_pull),
    .txn_start (txn_start),
    .txn_rw    (txn_rw),
    .txn_busy  (txn_busy)
  );
endmodule

// File: rtl/i2c_addr_front_chk.sv
module i2c_addr_front_chk #(
  parameter int                  PREFIX_W = 4,
  parameter logic [PREFIX_W-1:0] PREFIX   = 4'b1010,
  parameter int                  SEL_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             ev_fall,
  input logic [7:0]       addr_q,
  input logic [SEL_W-1:0] strap,
  input logic             sda_pull,
  input logic             txn_start,
  input logic             txn_rw,
  input logic             txn_busy
);
  AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (addr_q[7 -: PREFIX_W] == PREFIX && addr_q[SEL_W:1] == strap)); // R4
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(ev_fall || ev_start || ev_stop)); // R7
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !txn_start); // R8
  AST_START_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> ($past(sda_pull) && txn_busy)); // R8
  AST_RW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_busy && !txn_start) |-> $stable(txn_rw)); // R8
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!txn_busy && !sda_pull)); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (!txn_busy && !sda_pull)); // R10
endmodule

bind i2c_addr_front i2c_addr_front_chk #(.PREFIX_W(PREFIX_W), .PREFIX(PREFIX), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .ev_start  (ev.start),
  .ev_stop   (ev.stop),
  .ev_fall   (ev.scl_fall),
  .addr_q    (addr_q),
  .strap     (strap),
  .sda_pull  (sda_pull),
  .txn_start (txn_start),
  .txn_rw    (txn_rw),
  .txn_busy  (txn_busy)
);

// File: tb/test_i2c_addr_front.sv
`timescale 1ns/1ps
module test_i2c_addr_front;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic sda_pull, txn_start, txn_rw, txn_busy;
  logic sda_bus;

  int n_checks = 0;
  int n_errors = 0;
  int pulses = 0;
  logic last_rw = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_addr_front i_i2c_addr_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_m),
    .sda_in    (sda_bus),
    .strap     (strap),
    .sda_pull  (sda_pull),
    .txn_start (txn_start),
    .txn_rw    (txn_rw),
    .txn_busy  (txn_busy)
  );

  always @(posedge clk)
    if (txn_start) begin
      pulses  <= pulses + 1;
      last_rw <= txn_rw;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(P / 2);
    scl_m = 1'b1; wclk(P);
    sda_m = 1'b0; wclk(P);
    scl_m = 1'b0; wclk(P / 2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(P / 2);
    scl_m = 1'b1; wclk(P);
    sda_m = 1'b1; wclk(P);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wclk(P / 2);
      sda_m = b[i];
      wclk(P / 2);
      scl_m = 1'b1; wclk(P);
      scl_m = 1'b0;
    end
  endtask

  task automatic ack_clock(output logic pulled);
    wclk(P / 2);
    sda_m = 1'b1;
    wclk(P / 2);
    scl_m = 1'b1; wclk(P / 2);
    pulled = sda_pull;
    wclk(P / 2);
    scl_m = 1'b0; wclk(P);
  endtask

  task automatic transact(input logic [7:0] b, input string tag);
    logic pulled;
    int p0;
    bit exp;
    exp = (b[7:4] == 4'b1010) && (b[3:1] == strap);
    p0 = pulses;
    bus_start();
    send_bits(b, 8);
    ack_clock(pulled);
    check(pulled == exp, $sformatf("%s R7 ack byte=%02h strap=%0d", tag, b, strap), pulled, exp);
    check((pulses - p0) == int'(exp), $sformatf("%s R8 strobe count byte=%02h", tag, b), pulses - p0, int'(exp));
    check(txn_busy == exp, $sformatf("%s R9 busy byte=%02h", tag, b), txn_busy, exp);
    if (exp) check(last_rw == b[0], $sformatf("%s R6 rw byte=%02h", tag, b), last_rw, b[0]);
    bus_stop();
    wclk(4);
    check(txn_busy == 1'b0 && sda_pull == 1'b0, $sformatf("%s R10 stop clears", tag), txn_busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic pulled;
    int p0;
    wclk(5);
    check(sda_pull == 0 && txn_start == 0 && txn_busy == 0, "R1 reset outputs", {sda_pull, txn_start, txn_busy}, 0);
    rst_n = 1'b1;
    wclk(5);
    check(sda_pull == 0 && txn_busy == 0, "R1 after release", {sda_pull, txn_busy}, 0);

    // R3: matching byte clocked with no START before it
    strap = 3'd5;
    p0 = pulses;
    scl_m = 1'b0; wclk(P);
    send_bits(8'b1010_1011, 8);
    ack_clock(pulled);
    check(pulled == 0, "R3 no ack before START", pulled, 0);
    check(pulses == p0, "R3 no strobe before START", pulses - p0, 0);
    bus_stop();

    // R4 R5 R6: every strap value, full prefix and select sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int lo = 0; lo < 16; lo++) transact({4'b1010, 4'(lo)}, "R5 sweep");
      for (int hi = 0; hi < 16; hi++) transact({4'(hi), 3'(s), 1'b1}, "R4 prefix");
    end

    // full byte sweep at one strap
    strap = 3'd3;
    for (int b = 0; b < 256; b++) transact(8'(b), "R4 full");

    // R10: STOP mid-address, then bits without START
    strap = 3'd2;
    p0 = pulses;
    bus_start();
    send_bits(8'b1010_0100, 4);
    bus_stop();
    scl_m = 1'b0; wclk(P);
    send_bits(8'b1010_0100, 8);
    ack_clock(pulled);
    check(pulled == 0 && pulses == p0, "R10 stop aborts address", pulled, 0);
    bus_stop();

    // R10 R2: repeated START mid-address restarts reception
    p0 = pulses;
    bus_start();
    send_bits(8'b0000_0000, 4);
    bus_start();
    send_bits(8'b1010_0101, 8);
    ack_clock(pulled);
    check(pulled == 1, "R10 repeated start re-addresses", pulled, 1);
    check(pulses - p0 == 1 && last_rw == 1'b1, "R2 strobe after restart", pulses - p0, 1);
    check(txn_busy == 1, "R8 busy held", txn_busy, 1);

    // R2: SDA change with SCL high while busy is a START, not data
    bus_start();
    wclk(2);
    check(txn_busy == 0, "R2 start clears busy", txn_busy, 1'b0);
    send_bits(8'b1011_0100, 8);
    ack_clock(pulled);
    check(pulled == 0 && txn_busy == 0, "R9 mismatch after restart", pulled, 0);
    // R9: further clocks ignored until START
    send_bits(8'b1010_0100, 8);
    ack_clock(pulled);
    check(pulled == 0, "R9 ignored until START", pulled, 0);
    bus_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule